// File: doc/BRIEF.md
# Auto-Increment Packet Buffer Pointer Port

This block gives a host byte-level access to packet pages held in an external buffer memory. A 16-bit pointer register holds an 11-bit byte offset together with flag bits. One flag chooses between the page at the head of the receive queue and the page named by the packet-number input. Another flag turns on auto-increment, and a further flag records the read direction. A four-byte data window sits above the pointer. Each byte access through the window works out which page to use and which byte offset to address. It then drives a single-byte read or write into the page memory and, when auto-increment is on, moves the pointer forward.

A host access covers one to four consecutive register addresses. The block splits it into byte operations, one per clock cycle, in ascending address order. Every byte applies the addressing rule to the pointer as the previous byte left it. A one-cycle completion strobe then returns the assembled read data. The memory is read combinationally in the same cycle as the request.

Register addresses within the 16-byte window: 6 is the pointer low byte, 7 is the pointer high byte, and 8 to 11 are the data window (lane = address bits [1:0]). All other addresses are inert.

Top module: `bpp_port`

## Requirements
- R1: After reset the pointer is 0x0000, acc_ready_o is 1, acc_done_o is 0, acc_rdata_o is zero and mem_en_o is 0.
- R2: A byte write to address 6 loads pointer bits [7:0] only, and a byte write to address 7 loads bits [15:8] only. A read of address 6 returns bits [7:0]. A read of address 7 returns bits [15:8] AND 0xF7, so the not-empty flag (bit 11) always reads 0.
- R3: A data-window byte targets page rx_head_i when pointer bit 15 is 1, and page pkt_num_i when bit 15 is 0. The page number appears on mem_page_o.
- R4: With pointer bit 14 (auto-increment) set, a data byte addresses the current offset (bits [10:0]). The offset then advances by one, wrapping from 2047 to 0, and bits [15:11] are unchanged.
- R5: With bit 14 clear, a data byte addresses (offset + address[1:0]) mod 2048, and the pointer is not modified.
- R6: When the selected page number is 4 or more, a data byte causes no memory access, reads as 0 and does not advance the pointer.
- R7: An access of acc_len_i+1 bytes starting at acc_addr_i runs one byte per cycle on addresses acc_addr_i+k (mod 16) in ascending k. acc_ready_o is low while it runs. acc_done_o pulses for one cycle after the last byte.
- R8: acc_rdata_o bits [8k+7:8k] hold the byte read at step k. Bytes beyond the access length, and all bytes of a write access, are zero.
- R9: Addresses other than 6 to 11 ignore writes (pointer and memory untouched) and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Host access request, taken when acc_ready_o is 1 |
| acc_write_i | input | 1 | 1 = write access, 0 = read access |
| acc_addr_i | input | 4 | Start register address |
| acc_len_i | input | 2 | Number of bytes minus one |
| acc_wdata_i | input | 32 | Write bytes, byte k at bits [8k+7:8k] |
| acc_ready_o | output | 1 | Idle, can accept an access |
| acc_done_o | output | 1 | One-cycle completion strobe |
| acc_rdata_o | output | 32 | Assembled read bytes of the last access |
| pkt_num_i | input | 8 | Packet-number register value |
| rx_head_i | input | 8 | Page number at the head of the receive queue |
| mem_en_o | output | 1 | Memory byte access enable |
| mem_we_o | output | 1 | Memory byte write enable |
| mem_page_o | output | 2 | Page index |
| mem_addr_o | output | 11 | Byte offset within the page |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte, combinational from mem_page_o/mem_addr_o |

## Verification
The properties take the page inputs as sampled in the same cycle as each byte operation. They assume nothing about the memory's returned data, and they assume the pointer is changed only through this port. The stimulus changes pkt_num_i and rx_head_i only between host accesses. It draws page numbers from 0 to 5, so accesses to valid pages and to out-of-range pages both occur, while the expected address of each byte stays well defined. Random accesses favour the pointer and data addresses, so offset wrap and mixed pointer-then-data sequences inside one access come up often.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
  localparam int unsigned PTR_W     = 16;
  localparam int unsigned OFS_W     = 11;
  localparam int unsigned BIT_AUTO  = 14;
  localparam int unsigned BIT_RXSEL = 15;
  localparam logic [7:0]  PTR_HI_RD_MASK = 8'hF7;
  localparam logic [3:0]  REG_PTR_LO = 4'd6;
  localparam logic [3:0]  REG_PTR_HI = 4'd7;
  localparam logic [1:0]  DATA_WIN_TAG = 2'b10;

  typedef logic [OFS_W-1:0] ofs_t;
endpackage

// File: rtl/bpp_ptr_reg.sv
module bpp_ptr_reg
  import bpp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [7:0]       wbyte_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;
  ofs_t ofs_inc;

  assign ofs_inc = ptr_q[OFS_W-1:0] + ofs_t'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (wr_lo_i) begin
      ptr_q[7:0] <= wbyte_i;
    end else if (wr_hi_i) begin
      ptr_q[15:8] <= wbyte_i;
    end else if (inc_i) begin
      ptr_q[OFS_W-1:0] <= ofs_inc;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/bpp_data_map.sv
module bpp_data_map
  import bpp_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 4,
  parameter int unsigned PN_W      = 8,
  parameter int unsigned PG_W      = 2
) (
  input  logic            rxsel_i,
  input  logic            auto_i,
  input  ofs_t            ofs_i,
  input  logic [1:0]      lane_i,
  input  logic [PN_W-1:0] pkt_num_i,
  input  logic [PN_W-1:0] rx_head_i,
  output logic            page_ok_o,
  output logic [PG_W-1:0] page_o,
  output ofs_t            baddr_o
);
  logic [PN_W-1:0] sel;

  assign sel       = rxsel_i ? rx_head_i : pkt_num_i;
  assign page_ok_o = sel < PN_W'(NUM_PAGES);
  assign page_o    = sel[PG_W-1:0];
  // lane offset only applies without auto-increment; sum wraps at OFS_W bits
  assign baddr_o   = auto_i ? ofs_i : ofs_i + ofs_t'(lane_i);
endmodule

// File: rtl/bpp_seq.sv
module bpp_seq #(
  parameter int unsigned LANES = 4,
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned DW    = 8 * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic             acc_write_i,
  input  logic [3:0]       acc_addr_i,
  input  logic [IDX_W-1:0] acc_len_i,
  input  logic [DW-1:0]    acc_wdata_i,
  output logic             acc_ready_o,
  output logic             acc_done_o,
  output logic [DW-1:0]    acc_rdata_o,
  output logic             op_act_o,
  output logic             op_we_o,
  output logic [3:0]       op_addr_o,
  output logic [7:0]       op_wbyte_o,
  input  logic [7:0]       op_rbyte_i
);
  logic             busy_q, done_q, we_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic [3:0]       base_q;
  logic [DW-1:0]    wdata_q;
  logic [7:0]       wlane [LANES];
  logic [7:0]       rlane [LANES];
  logic             accept, at_last;

  assign accept  = acc_valid_i && !busy_q;
  assign at_last = busy_q && (idx_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      we_q    <= 1'b0;
      idx_q   <= '0;
      last_q  <= '0;
      base_q  <= '0;
      wdata_q <= '0;
    end else begin
      done_q <= at_last;
      if (accept) begin
        busy_q  <= 1'b1;
        we_q    <= acc_write_i;
        idx_q   <= '0;
        last_q  <= acc_len_i;
        base_q  <= acc_addr_i;
        wdata_q <= acc_wdata_i;
      end else if (at_last) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wlane[g] = wdata_q[8*g +: 8];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rlane[g] <= '0;
      end else if (accept) begin
        rlane[g] <= '0;
      end else if (busy_q && !we_q && idx_q == IDX_W'(g)) begin
        rlane[g] <= op_rbyte_i;
      end
    end
    assign acc_rdata_o[8*g +: 8] = rlane[g];
  end

  assign acc_ready_o = !busy_q;
  assign acc_done_o  = done_q;
  assign op_act_o    = busy_q;
  assign op_we_o     = we_q;
  assign op_addr_o   = base_q + 4'(idx_q);
  assign op_wbyte_o  = wlane[idx_q];
endmodule

// File: rtl/bpp_port.sv
module bpp_port
  import bpp_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 4,
  parameter int unsigned PN_W      = 8,
  parameter int unsigned LANES     = 4,
  localparam int unsigned PG_W  = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned DW    = 8 * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic             acc_write_i,
  input  logic [3:0]       acc_addr_i,
  input  logic [IDX_W-1:0] acc_len_i,
  input  logic [DW-1:0]    acc_wdata_i,
  output logic             acc_ready_o,
  output logic             acc_done_o,
  output logic [DW-1:0]    acc_rdata_o,
  input  logic [PN_W-1:0]  pkt_num_i,
  input  logic [PN_W-1:0]  rx_head_i,
  output logic             mem_en_o,
  output logic             mem_we_o,
  output logic [PG_W-1:0]  mem_page_o,
  output logic [OFS_W-1:0] mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  input  logic [7:0]       mem_rdata_i
);
  logic             op_act, op_we;
  logic [3:0]       op_addr;
  logic [7:0]       op_wbyte, op_rbyte;
  logic [PTR_W-1:0] ptr_w;
  logic             hit_lo, hit_hi, hit_data, page_ok, data_go;
  logic [PG_W-1:0]  page;
  ofs_t             baddr;

  bpp_seq #(.LANES(LANES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid_i),
    .acc_write_i (acc_write_i),
    .acc_addr_i  (acc_addr_i),
    .acc_len_i   (acc_len_i),
    .acc_wdata_i (acc_wdata_i),
    .acc_ready_o (acc_ready_o),
    .acc_done_o  (acc_done_o),
    .acc_rdata_o (acc_rdata_o),
    .op_act_o    (op_act),
    .op_we_o     (op_we),
    .op_addr_o   (op_addr),
    .op_wbyte_o  (op_wbyte),
    .op_rbyte_i  (op_rbyte)
  );

  assign hit_lo   = op_act && (op_addr == REG_PTR_LO);
  assign hit_hi   = op_act && (op_addr == REG_PTR_HI);
  assign hit_data = op_act && (op_addr[3:2] == DATA_WIN_TAG);
  assign data_go  = hit_data && page_ok;

  bpp_data_map #(.NUM_PAGES(NUM_PAGES), .PN_W(PN_W), .PG_W(PG_W)) u_map (
    .rxsel_i   (ptr_w[BIT_RXSEL]),
    .auto_i    (ptr_w[BIT_AUTO]),
    .ofs_i     (ptr_w[OFS_W-1:0]),
    .lane_i    (op_addr[1:0]),
    .pkt_num_i (pkt_num_i),
    .rx_head_i (rx_head_i),
    .page_ok_o (page_ok),
    .page_o    (page),
    .baddr_o   (baddr)
  );

  bpp_ptr_reg u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (hit_lo && op_we),
    .wr_hi_i (hit_hi && op_we),
    .wbyte_i (op_wbyte),
    .inc_i   (data_go && ptr_w[BIT_AUTO]),
    .ptr_o   (ptr_w)
  );

  always_comb begin
    op_rbyte = 8'h00;
    if (hit_lo)       op_rbyte = ptr_w[7:0];
    else if (hit_hi)  op_rbyte = ptr_w[15:8] & PTR_HI_RD_MASK;
    else if (data_go) op_rbyte = mem_rdata_i;
  end

  assign mem_en_o    = data_go;
  assign mem_we_o    = data_go && op_we;
  assign mem_page_o  = page;
  assign mem_addr_o  = baddr;
  assign mem_wdata_o = op_wbyte;
endmodule

// File: rtl/bpp_port_chk.sv
module bpp_port_chk #(
  parameter int unsigned NUM_PAGES = 4,
  parameter int unsigned PN_W      = 8,
  parameter int unsigned PG_W      = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [10:0]     ofs_i,
  input logic            auto_i,
  input logic            rxsel_i,
  input logic [PN_W-1:0] pkt_num_i,
  input logic [PN_W-1:0] rx_head_i,
  input logic            mem_en_o,
  input logic [PG_W-1:0] mem_page_o,
  input logic [10:0]     mem_addr_o,
  input logic            acc_done_o,
  input logic            acc_ready_o
);
  logic [PN_W-1:0] sel;
  assign sel = rxsel_i ? rx_head_i : pkt_num_i;

  a_r3_page_follows_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> mem_page_o == sel[PG_W-1:0]);

  a_r6_no_access_bad_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> sel < PN_W'(NUM_PAGES));

  a_r4_auto_uses_ofs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && auto_i) |-> mem_addr_o == ofs_i);

  a_r4_auto_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && auto_i) |=> ofs_i == $past(ofs_i) + 11'd1);

  a_r5_ptr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && !auto_i) |=> ($stable(ofs_i) && $stable(auto_i) && $stable(rxsel_i)));

  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_done_o |-> acc_ready_o);

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_done_o |=> !acc_done_o);

  a_r7_no_mem_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> !acc_ready_o);
endmodule

bind bpp_port bpp_port_chk #(.NUM_PAGES(NUM_PAGES), .PN_W(PN_W), .PG_W(PG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ofs_i       (ptr_w[10:0]),
  .auto_i      (ptr_w[14]),
  .rxsel_i     (ptr_w[15]),
  .pkt_num_i   (pkt_num_i),
  .rx_head_i   (rx_head_i),
  .mem_en_o    (mem_en_o),
  .mem_page_o  (mem_page_o),
  .mem_addr_o  (mem_addr_o),
  .acc_done_o  (acc_done_o),
  .acc_ready_o (acc_ready_o)
);

// File: tb/bpp_port_test.sv
module bpp_port_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0, acc_write_i = 1'b0;
  logic [3:0]  acc_addr_i = '0;
  logic [1:0]  acc_len_i = '0;
  logic [31:0] acc_wdata_i = '0;
  logic        acc_ready_o, acc_done_o;
  logic [31:0] acc_rdata_o;
  logic [7:0]  pkt_num_i = '0, rx_head_i = '0;
  logic        mem_en_o, mem_we_o;
  logic [1:0]  mem_page_o;
  logic [10:0] mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_ptr = '0;

  always #2 clk_i = ~clk_i;

  function automatic logic [7:0] mem_hash(input logic [1:0] pg, input logic [10:0] a);
    return a[7:0] ^ {a[10:8], 5'b10101} ^ (8'h5B * {6'b0, pg});
  endfunction

  assign mem_rdata_i = mem_hash(mem_page_o, mem_addr_o);

  bpp_port uut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_acc(input bit wr, input logic [3:0] addr, input logic [1:0] len,
                        input logic [31:0] wd);
    logic [31:0] exp_rd;
    exp_rd = '0;
    @(negedge clk_i);
    chk(acc_ready_o == 1'b1, "R7", "ready before access", {31'b0, acc_ready_o}, 32'd1);
    acc_valid_i = 1'b1; acc_write_i = wr; acc_addr_i = addr;
    acc_len_i = len; acc_wdata_i = wd;
    @(negedge clk_i);
    acc_valid_i = 1'b0;
    for (int k = 0; k <= int'(len); k++) begin
      logic [3:0]  a;
      logic [7:0]  b, sel, rb;
      logic [10:0] ofs, ea;
      string       tag;
      bit          en;
      a = addr + 4'(k);
      b = wd[8*k +: 8];
      rb = 8'h00; en = 1'b0; ea = '0;
      ofs = m_ptr[10:0];
      sel = m_ptr[15] ? rx_head_i : pkt_num_i;
      chk(acc_ready_o == 1'b0, "R7", "ready while busy", {31'b0, acc_ready_o}, 32'd0);
      if (a == 4'd6 || a == 4'd7) begin
        tag = "R2";
        if (wr) begin
          if (a == 4'd6) m_ptr[7:0] = b; else m_ptr[15:8] = b;
        end else begin
          rb = (a == 4'd6) ? m_ptr[7:0] : (m_ptr[15:8] & 8'hF7);
        end
      end else if (a[3:2] == 2'b10) begin
        if (sel >= 8'd4) begin
          tag = "R6";
        end else begin
          en = 1'b1;
          tag = m_ptr[14] ? "R4" : "R5";
          ea = m_ptr[14] ? ofs : ofs + {9'b0, a[1:0]};
          if (!wr) rb = mem_hash(sel[1:0], ea);
          if (m_ptr[14]) m_ptr[10:0] = ofs + 11'd1;
        end
      end else begin
        tag = "R9";
      end
      chk(mem_en_o == en, tag, "mem enable", {31'b0, mem_en_o}, {31'b0, en});
      if (en) begin
        chk(mem_page_o == sel[1:0], "R3", "page", {30'b0, mem_page_o}, {24'b0, sel});
        chk(mem_addr_o == ea, tag, "byte address", {21'b0, mem_addr_o}, {21'b0, ea});
        chk(mem_we_o == wr, tag, "write enable", {31'b0, mem_we_o}, {31'b0, wr});
        if (wr) chk(mem_wdata_o == b, "R7", "write byte", {24'b0, mem_wdata_o}, {24'b0, b});
      end
      exp_rd[8*k +: 8] = rb;
      @(negedge clk_i);
    end
    chk(acc_done_o == 1'b1, "R7", "done strobe", {31'b0, acc_done_o}, 32'd1);
    chk(acc_rdata_o == exp_rd, "R8", "read data", acc_rdata_o, exp_rd);
    @(negedge clk_i);
    chk(acc_done_o == 1'b0, "R7", "done one cycle", {31'b0, acc_done_o}, 32'd0);
  endtask

  task automatic check_ptr(input string tag);
    do_acc(1'b0, 4'd6, 2'd1, 32'h0);
    chk(acc_rdata_o[15:0] == {m_ptr[15:8] & 8'hF7, m_ptr[7:0]}, tag, "pointer readback",
        {16'b0, acc_rdata_o[15:0]}, {16'b0, m_ptr[15:8] & 8'hF7, m_ptr[7:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(acc_ready_o == 1'b1, "R1", "ready in reset", {31'b0, acc_ready_o}, 32'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(acc_done_o == 1'b0, "R1", "done after reset", {31'b0, acc_done_o}, 32'd0);
    chk(acc_rdata_o == 32'h0, "R1", "rdata after reset", acc_rdata_o, 32'h0);
    chk(mem_en_o == 1'b0, "R1", "mem idle after reset", {31'b0, mem_en_o}, 32'd0);
    check_ptr("R1");

    // R2: independent byte writes, high byte mask hides bit 11
    do_acc(1'b1, 4'd7, 2'd0, 32'h0000_00CF);
    check_ptr("R2");
    do_acc(1'b1, 4'd6, 2'd0, 32'h0000_00FE);
    check_ptr("R2");

    // R4: auto-increment on rx page, wrap 0x7FE..0x001
    rx_head_i = 8'd2; pkt_num_i = 8'd1;
    do_acc(1'b0, 4'd8, 2'd3, 32'h0);
    check_ptr("R4");

    // R5: fixed pointer, lanes add with wrap; pointer held
    do_acc(1'b1, 4'd6, 2'd1, 32'h0000_07FD);
    do_acc(1'b1, 4'd8, 2'd3, 32'hA1B2_C3D4);
    check_ptr("R5");

    // R6: bad page, auto-increment set, pointer must stay
    pkt_num_i = 8'd5;
    do_acc(1'b1, 4'd6, 2'd1, 32'h0000_400A);
    do_acc(1'b1, 4'd8, 2'd3, 32'h1122_3344);
    do_acc(1'b0, 4'd9, 2'd2, 32'h0);
    check_ptr("R6");

    // R9: inert addresses
    do_acc(1'b1, 4'd2, 2'd3, 32'hFFFF_FFFF);
    do_acc(1'b1, 4'd12, 2'd3, 32'hFFFF_FFFF);
    do_acc(1'b0, 4'd0, 2'd3, 32'h0);
    check_ptr("R9");

    // R7: access spanning pointer then data in one go
    pkt_num_i = 8'd3;
    do_acc(1'b1, 4'd6, 2'd3, 32'h5A5A_47F0);
    check_ptr("R7");

    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      logic [3:0] a;
      r = $urandom % 4;
      a = (r < 2) ? 4'(4'd8 + 4'($urandom % 4)) : (r == 2) ? 4'(4'd6 + 4'($urandom % 2))
                                                              : 4'($urandom);
      pkt_num_i = 8'($urandom % 6);
      rx_head_i = 8'($urandom % 6);
      do_acc(1'($urandom), a, 2'($urandom), $urandom);
      if (i % 50 == 0) check_ptr("R2");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule